// File: doc/BRIEF.md
# Serial IR Receive Frame Unwrapper

This block sits between a byte-level asynchronous IR receiver and a receive FIFO. It scans the incoming byte stream for frame boundaries, removes the framing and transparency bytes, and forwards only the bare payload, including the trailing 16-bit check field, which is passed on without being checked. Each forwarded byte appears on a one-cycle `pay_valid` strobe.

A frame opens on the start flag 0xC0 and closes on the end flag 0xC1. The escape byte 0x7D is dropped, and the byte after it is XOR-ed with 0x20 before it is forwarded. A 12-bit counter tracks the forwarded bytes of the current frame. When a frame closes, the block raises a one-cycle `fin_valid` pulse that carries the final count and three error bits. The errors cover a start flag arriving inside an open frame (the end flag went missing), an end flag right after an escape (encoding error), and a frame longer than the programmed limit.

Top module: `sir_rx_unwrap`

## Requirements
- R1: After reset, `pay_valid` and `fin_valid` are low and the block is hunting for a start flag.
- R2: `flag_word` reads the start flag in bits [7:0] and the end flag in bits [15:8], that is 16'hC1C0.
- R3: While no frame is open, every byte other than 0xC0 is discarded and produces no output.
- R4: Inside an open frame, a byte other than 0xC0, 0xC1 or 0x7D is forwarded on `pay_byte` with `pay_valid` high in the cycle after the byte is accepted.
- R5: Inside a frame, 0x7D is not forwarded. The next byte (if it is not 0xC0 or 0xC1) is forwarded XOR 0x20.
- R6: Extra 0xC0 bytes after a start flag and before the first payload byte or escape are dropped silently, with no `fin_valid`.
- R7: 0xC1 in an open frame raises `fin_valid` one cycle later with `fin_count` equal to the number of forwarded bytes and no error bits. The block then hunts again.
- R8: 0xC0 arriving after a forwarded byte or a pending escape raises `fin_valid` with `fin_no_eof` set and the count so far. It also opens a new frame at count zero.
- R9: 0xC1 directly after 0x7D raises `fin_valid` with `fin_phy_err` set.
- R10: `fin_len_err` is set when the frame's count exceeds `max_len` as sampled on the closing byte. A count equal to `max_len` is not an error.
- R11: The byte count restarts at zero for every new frame.
- R12: `fin_valid` never coincides with `pay_valid`, and the error bits are high only together with `fin_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| max_len | input | 12 | Largest accepted payload length |
| flag_word | output | 16 | Constant flags: start low byte, end high byte |
| pay_valid | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Unwrapped payload byte |
| fin_valid | output | 1 | End-of-frame pulse |
| fin_count | output | 12 | Payload byte count of the closed frame |
| fin_no_eof | output | 1 | Frame closed by a start flag |
| fin_phy_err | output | 1 | End flag followed an escape |
| fin_len_err | output | 1 | Frame longer than max_len |

## Verification
The hardest cases to reach are the two abort paths that involve a pending escape. In the first, a start flag follows 0x7D before any payload byte has been stored. It must count as a missing end flag, not as a harmless leading flag. In the second, an end flag follows 0x7D and must be reported as an encoding error. Directed byte sequences drive the unwrapper into the escape-pending state at count zero and at a non-zero count, then close the frame with each flag. The bench also checks that the frame reopened after an abort counts from zero.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;
   localparam logic [7:0] SOF_CODE = 8'hC0;
   localparam logic [7:0] EOF_CODE = 8'hC1;
   localparam logic [7:0] ESC_CODE = 8'h7D;
   localparam logic [7:0] ESC_FLIP = 8'h20;

   typedef enum logic [1:0] {ST_HUNT, ST_OPEN, ST_ESC} rx_state_t;
   typedef enum logic [1:0] {K_DATA, K_SOF, K_EOF, K_ESC} byte_kind_t;
endpackage

// File: rtl/sir_byte_class.sv
module sir_byte_class
   import sir_unwrap_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] b,
   output byte_kind_t        kind
);
   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("sir_byte_class: BYTE_W must be 8");
      end
   endgenerate

   always_comb begin
      if (b == SOF_CODE)      kind = K_SOF;
      else if (b == EOF_CODE) kind = K_EOF;
      else if (b == ESC_CODE) kind = K_ESC;
      else                    kind = K_DATA;
   end
endmodule

// File: rtl/sir_len_track.sv
module sir_len_track #(
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] max_len,
   output logic [CNT_W-1:0] cnt,
   output logic             empty,
   output logic             over
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   logic spill;

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("sir_len_track: CNT_W too small");
      end
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt   <= '0;
               spill <= 1'b0;
            end else if (inc) begin
               if (cnt == CNT_TOP) spill <= 1'b1;
               else                cnt   <= cnt + 1'b1;
            end
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt   <= '0;
               spill <= 1'b0;
            end else if (inc) begin
               cnt <= cnt + 1'b1;
               if (cnt == CNT_TOP) spill <= 1'b1;
            end
         end
      end
   endgenerate

   assign empty = (cnt == '0) && !spill;
   assign over  = spill || (cnt > max_len);

   a_r11_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/sir_rx_unwrap.sv
module sir_rx_unwrap
   import sir_unwrap_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic [CNT_W-1:0]  max_len,
   output logic [15:0]       flag_word,
   output logic              pay_valid,
   output logic [7:0]        pay_byte,
   output logic              fin_valid,
   output logic [CNT_W-1:0]  fin_count,
   output logic              fin_no_eof,
   output logic              fin_phy_err,
   output logic              fin_len_err
);
   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("sir_rx_unwrap: BYTE_W must be 8");
      end
   endgenerate

   rx_state_t  state, state_nx;
   byte_kind_t kind;
   logic [CNT_W-1:0] cnt;
   logic cnt_empty, cnt_over;
   logic store, close, err_miss, err_phy, clr;
   logic [7:0] store_byte;

   assign flag_word = {EOF_CODE, SOF_CODE};

   sir_byte_class #(.BYTE_W(BYTE_W)) u_class (
      .b    (rx_byte),
      .kind (kind)
   );

   sir_len_track #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .inc     (store),
      .max_len (max_len),
      .cnt     (cnt),
      .empty   (cnt_empty),
      .over    (cnt_over)
   );

   always_comb begin
      state_nx   = state;
      store      = 1'b0;
      store_byte = rx_byte;
      close      = 1'b0;
      err_miss   = 1'b0;
      err_phy    = 1'b0;
      clr        = 1'b0;
      if (rx_valid) begin
         unique case (state)
            ST_HUNT: begin
               if (kind == K_SOF) begin
                  state_nx = ST_OPEN;
                  clr      = 1'b1;
               end
            end
            ST_OPEN: begin
               unique case (kind)
                  K_SOF: begin
                     clr = 1'b1;
                     if (!cnt_empty) begin
                        close    = 1'b1;
                        err_miss = 1'b1;
                     end
                  end
                  K_EOF: begin
                     close    = 1'b1;
                     state_nx = ST_HUNT;
                  end
                  K_ESC:  state_nx = ST_ESC;
                  default: store = 1'b1;
               endcase
            end
            ST_ESC: begin
               unique case (kind)
                  K_SOF: begin
                     close    = 1'b1;
                     err_miss = 1'b1;
                     clr      = 1'b1;
                     state_nx = ST_OPEN;
                  end
                  K_EOF: begin
                     close    = 1'b1;
                     err_phy  = 1'b1;
                     state_nx = ST_HUNT;
                  end
                  default: begin
                     store      = 1'b1;
                     store_byte = rx_byte ^ ESC_FLIP;
                     state_nx   = ST_OPEN;
                  end
               endcase
            end
            default: state_nx = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_HUNT;
         pay_valid   <= 1'b0;
         pay_byte    <= '0;
         fin_valid   <= 1'b0;
         fin_count   <= '0;
         fin_no_eof  <= 1'b0;
         fin_phy_err <= 1'b0;
         fin_len_err <= 1'b0;
      end else begin
         state       <= state_nx;
         pay_valid   <= store;
         if (store) pay_byte <= store_byte;
         fin_valid   <= close;
         if (close) fin_count <= cnt;
         fin_no_eof  <= err_miss;
         fin_phy_err <= err_phy;
         fin_len_err <= close && cnt_over;
      end
   end

   a_r12_no_byte_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> !pay_valid);
   a_r12_err_needs_fin: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_no_eof || fin_phy_err || fin_len_err) |-> fin_valid);
   a_r9_errs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> ($countones({fin_no_eof, fin_phy_err}) <= 1));
   a_r4_pay_from_input: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> $past(rx_valid));
   a_r7_fin_from_flag: assert property (@(posedge clk) disable iff (!rst_n)
      fin_valid |-> ($past(rx_valid) &&
                     ($past(rx_byte) == SOF_CODE || $past(rx_byte) == EOF_CODE)));
   a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_valid && !fin_len_err) |-> (fin_count <= $past(max_len)));
endmodule

// File: tb/sim_sir_rx_unwrap.sv
module sim_sir_rx_unwrap;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [11:0] max_len = 12'd100;
   logic [15:0] flag_word;
   logic        pay_valid, fin_valid, fin_no_eof, fin_phy_err, fin_len_err;
   logic [7:0]  pay_byte;
   logic [11:0] fin_count;

   int n_chk = 0, n_fail = 0, viol = 0;
   logic [7:0]  cap_b [0:31];
   int          cap_n = 0;
   logic [11:0] fin_c [0:7];
   logic [2:0]  fin_e [0:7];
   int          fin_n = 0;

   always #10 clk = ~clk;

   sir_rx_unwrap u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .max_len(max_len), .flag_word(flag_word), .pay_valid(pay_valid),
      .pay_byte(pay_byte), .fin_valid(fin_valid), .fin_count(fin_count),
      .fin_no_eof(fin_no_eof), .fin_phy_err(fin_phy_err), .fin_len_err(fin_len_err)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (pay_valid && cap_n < 32) begin cap_b[cap_n] = pay_byte; cap_n++; end
         if (fin_valid && fin_n < 8) begin
            fin_c[fin_n] = fin_count;
            fin_e[fin_n] = {fin_no_eof, fin_phy_err, fin_len_err};
            fin_n++;
         end
         if (fin_valid && pay_valid) viol++;
         if (!fin_valid && (fin_no_eof || fin_phy_err || fin_len_err)) viol++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
   endtask

   task automatic settle();
      @(negedge clk);
      rx_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_cap();
      #1;
      cap_n = 0;
      fin_n = 0;
   endtask

   task automatic t_reset();
      check("R1 pay_valid after reset", int'(pay_valid), 0);
      check("R1 fin_valid after reset", int'(fin_valid), 0);
      check("R2 flag_word", int'(flag_word), 16'hC1C0);
   endtask

   task automatic t_basic();
      clear_cap();
      send(8'hFF); send(8'hFF); send(8'h11);
      send(8'hC0); send(8'hC0); send(8'hC0);
      send(8'h01); send(8'h02); send(8'h03); send(8'hC1);
      send(8'h44);
      settle();
      check("R3 R4 forwarded byte count", cap_n, 3);
      check("R4 byte0", int'(cap_b[0]), 8'h01);
      check("R4 byte2", int'(cap_b[2]), 8'h03);
      check("R6 single end pulse", fin_n, 1);
      check("R7 final count", int'(fin_c[0]), 3);
      check("R7 no errors", int'(fin_e[0]), 0);
   endtask

   task automatic t_escape();
      clear_cap();
      send(8'hC0); send(8'h7D); send(8'h5E); send(8'h7D); send(8'h5D);
      send(8'h7D); send(8'hE1); send(8'hAA); send(8'hC1);
      settle();
      check("R5 escaped count", cap_n, 4);
      check("R5 byte0", int'(cap_b[0]), 8'h7E);
      check("R5 byte1", int'(cap_b[1]), 8'h7D);
      check("R5 byte2", int'(cap_b[2]), 8'hC1);
      check("R5 byte3", int'(cap_b[3]), 8'hAA);
      check("R5 frame count", int'(fin_c[0]), 4);
   endtask

   task automatic t_missing();
      clear_cap();
      send(8'hC0); send(8'h01); send(8'h02); send(8'hC0); send(8'h03); send(8'hC1);
      settle();
      check("R8 two pulses", fin_n, 2);
      check("R8 aborted count", int'(fin_c[0]), 2);
      check("R8 missing-end flag", int'(fin_e[0]), 3'b100);
      check("R11 reopened count", int'(fin_c[1]), 1);
      check("R11 reopened clean", int'(fin_e[1]), 0);
   endtask

   task automatic t_esc_sof();
      clear_cap();
      send(8'hC0); send(8'h7D); send(8'hC0); send(8'h04); send(8'hC1);
      settle();
      check("R8 escape then start pulses", fin_n, 2);
      check("R8 escape-abort count", int'(fin_c[0]), 0);
      check("R8 escape-abort flag", int'(fin_e[0]), 3'b100);
      check("R11 next frame count", int'(fin_c[1]), 1);
   endtask

   task automatic t_phy();
      clear_cap();
      send(8'hC0); send(8'h05); send(8'h7D); send(8'hC1); send(8'h06);
      settle();
      check("R9 one pulse", fin_n, 1);
      check("R9 phy flag", int'(fin_e[0]), 3'b010);
      check("R9 count", int'(fin_c[0]), 1);
      check("R3 byte after close dropped", cap_n, 1);
   endtask

   task automatic t_len();
      clear_cap();
      max_len = 12'd3;
      send(8'hC0); send(8'h01); send(8'h02); send(8'h03); send(8'hC1);
      send(8'hC0); send(8'h01); send(8'h02); send(8'h03); send(8'h04); send(8'hC1);
      settle();
      check("R10 two frames", fin_n, 2);
      check("R10 equal length clean", int'(fin_e[0]), 0);
      check("R10 over length flagged", int'(fin_e[1]), 3'b001);
      check("R10 over length count", int'(fin_c[1]), 4);
      max_len = 12'd100;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_escape();
      t_missing();
      t_esc_sof();
      t_phy();
      t_len();
      check("R12 fin and pay exclusive, errors only with fin", viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule